// File: doc/BRIEF.md
# Line 21/284 Closed Caption Inserter

This block puts closed-caption waveforms on the two NTSC caption lines: line 21 of field one and line 284 of field two. A register port accepts writes for two character bytes per line, an enable bit per line, an interrupt mask and an interrupt clear. The timing generator supplies the line number, the field bit and the horizontal pixel position. When an enabled caption line reaches the configured horizontal start position, the block latches that line's character pair. It then drives a luma override stream. The stream holds seven run-in clock periods, the start bits 0, 0, 1, and sixteen data bits. The first character goes first and each character is sent least significant bit first.

Hardware sets the top bit of each character to odd parity over the seven lower bits. If nothing was written for a line since its last transmission, two null characters are sent. When a line's waveform ends, the block raises that line's completion flag. Software can then refill the data one line at a time. It can gate each flag onto the interrupt pin through a mask and clear it by writing ones.

Top module: `cc_inserter`

## Requirements
- R1: A waveform starts only on line 21 with field 0 when enable bit 0 (register address 0) is 1, or on line 284 with field 1 when enable bit 1 is 1. On any other line, field or enable setting, `cc_active_o` stays 0 and no flag changes.
- R2: Output begins the cycle after the start position is sampled. The first 7 bit periods (BIT_CLKS cycles each) are run-in clock: the bit is 1 for the first BIT_CLKS/2 cycles of each period and 0 for the rest.
- R3: Bit periods 8, 9 and 10 carry the start bits 0, 0, 1 in that order.
- R4: The next 16 bit periods carry the first character and then the second, each least significant bit first. Character bit 7 is odd parity over its bits 6:0, and the host's written bit 7 is ignored. Line 21 characters are at addresses 4 and 5, and line 284 characters are at addresses 6 and 7.
- R5: If neither character address of a line was written since that line last started a waveform, both characters are sent as 0x80.
- R6: The character pair is latched when the waveform starts. A write during transmission changes only the line's next waveform.
- R7: In the first cycle after the last data bit period, `cc_active_o` is 0 and the line's flag in `cc_flags_o` is 1 (bit 0 is line 21, bit 1 is line 284).
- R8: `irq_o` is the OR of the flags ANDed with the mask at address 1 (same bit order). Writing a 1 to a bit at address 2 clears that flag, unless the same flag is being set in that cycle.
- R9: After reset the enables, mask and flags are 0, and `cc_active_o`, `cc_luma_o` and `irq_o` are 0.
- R10: While active, `cc_luma_o` is LVL_HI for a 1 bit and LVL_LO for a 0 bit. It is 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| line_i | input | LINE_W | Current line number from timing generator |
| field_i | input | 1 | Field bit, 0 = field one |
| hpos_i | input | H_W | Horizontal pixel position |
| cc_active_o | output | 1 | Luma override active |
| cc_luma_o | output | LVL_W | Caption luma level |
| cc_flags_o | output | 2 | Completion flags, bit 0 line 21, bit 1 line 284 |
| irq_o | output | 1 | Masked interrupt |

## Verification
A bit counter or period counter off by one shifts the whole waveform in time. That shows at `cc_active_o` and `cc_luma_o` within one bit period of the start, or at the latest as an early or late fall of `cc_active_o`. A wrong latch, parity or freshness state corrupts the data bits of that same line. A stale freshness bit is caught on the next line of the same field. Wrong flag or mask state appears on `cc_flags_o` and `irq_o` in the cycle after the waveform ends or after the register write.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
  localparam int unsigned RUNIN_SLOTS = 7;
  localparam int unsigned START_SLOTS = 3;
  localparam int unsigned DATA_BITS   = 16;
  localparam int unsigned TOTAL_SLOTS = RUNIN_SLOTS + START_SLOTS + DATA_BITS;
  localparam int unsigned SLOT_W      = $clog2(TOTAL_SLOTS);

  typedef enum logic [2:0] {
    ADDR_ENABLE = 3'd0,
    ADDR_MASK   = 3'd1,
    ADDR_CLEAR  = 3'd2,
    ADDR_A_C1   = 3'd4,
    ADDR_A_C2   = 3'd5,
    ADDR_B_C1   = 3'd6,
    ADDR_B_C2   = 3'd7
  } cc_addr_e;

  function automatic logic [7:0] with_odd_parity(input logic [6:0] c);
    return {~(^c), c};
  endfunction
endpackage

// File: rtl/cc_regs.sv
`timescale 1ns/1ps
module cc_regs
  import cc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [2:0]  wr_addr_i,
  input  logic [7:0]  wr_data_i,
  input  logic [1:0]  latch_i,
  input  logic [1:0]  done_i,
  output logic [1:0]  en_o,
  output logic [15:0] pair_a_o,
  output logic [15:0] pair_b_o,
  output logic [1:0]  flags_o,
  output logic        irq_o
);
  logic [1:0]      en_q, en_d;
  logic [1:0]      mask_q, mask_d;
  logic [1:0]      flag_q, flag_d;
  logic [1:0]      fresh_q, fresh_d;
  logic [3:0][6:0] chr_q, chr_d;
  logic [1:0]      clr_bits;
  logic [1:0][15:0] pair;
  logic            unused_wr_msb;

  assign unused_wr_msb = wr_data_i[7];
  assign clr_bits = (wr_en_i && wr_addr_i == ADDR_CLEAR) ? wr_data_i[1:0] : 2'b00;

  always_comb begin
    en_d    = en_q;
    mask_d  = mask_q;
    chr_d   = chr_q;
    flag_d  = (flag_q & ~clr_bits) | done_i;
    fresh_d = fresh_q & ~latch_i;
    if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_ENABLE: en_d   = wr_data_i[1:0];
        ADDR_MASK:   mask_d = wr_data_i[1:0];
        ADDR_A_C1:   begin chr_d[0] = wr_data_i[6:0]; fresh_d[0] = 1'b1; end
        ADDR_A_C2:   begin chr_d[1] = wr_data_i[6:0]; fresh_d[0] = 1'b1; end
        ADDR_B_C1:   begin chr_d[2] = wr_data_i[6:0]; fresh_d[1] = 1'b1; end
        ADDR_B_C2:   begin chr_d[3] = wr_data_i[6:0]; fresh_d[1] = 1'b1; end
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mask_q  <= '0;
      flag_q  <= '0;
      fresh_q <= '0;
      chr_q   <= '0;
    end else begin
      en_q    <= en_d;
      mask_q  <= mask_d;
      flag_q  <= flag_d;
      fresh_q <= fresh_d;
      chr_q   <= chr_d;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_line
    assign pair[g] = fresh_q[g]
      ? {with_odd_parity(chr_q[2*g+1]), with_odd_parity(chr_q[2*g])}
      : 16'h8080;

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == ADDR_CLEAR && wr_data_i[g] && !done_i[g]) |=> !flag_q[g]);
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_i[g] |=> flag_q[g]);
  end

  assign en_o     = en_q;
  assign pair_a_o = pair[0];
  assign pair_b_o = pair[1];
  assign flags_o  = flag_q;
  assign irq_o    = |(flag_q & mask_q);
endmodule

// File: rtl/cc_serializer.sv
`timescale 1ns/1ps
module cc_serializer
  import cc_pkg::*;
#(
  parameter int unsigned BIT_CLKS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [15:0] data_i,
  output logic        busy_o,
  output logic        bit_o,
  output logic        done_o
);
  localparam int unsigned TICK_W = $clog2(BIT_CLKS);
  localparam int unsigned HALF   = BIT_CLKS / 2;

  logic              busy_q, busy_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic [15:0]       data_q, data_d;
  logic              last_tick, last_slot;
  logic [3:0]        didx;

  assign last_tick = tick_q == TICK_W'(BIT_CLKS - 1);
  assign last_slot = slot_q == SLOT_W'(TOTAL_SLOTS - 1);
  assign done_o    = busy_q && last_tick && last_slot;

  always_comb begin
    busy_d = busy_q;
    slot_d = slot_q;
    tick_d = tick_q;
    data_d = data_q;
    if (start_i && !busy_q) begin
      busy_d = 1'b1;
      slot_d = '0;
      tick_d = '0;
      data_d = data_i;
    end else if (busy_q) begin
      if (last_tick) begin
        tick_d = '0;
        if (last_slot) busy_d = 1'b0;
        else           slot_d = slot_q + 1'b1;
      end else begin
        tick_d = tick_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      tick_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      slot_q <= slot_d;
      tick_q <= tick_d;
      data_q <= data_d;
    end
  end

  assign didx = 4'(slot_q - SLOT_W'(RUNIN_SLOTS + START_SLOTS));

  always_comb begin
    if (slot_q < SLOT_W'(RUNIN_SLOTS))
      bit_o = tick_q < TICK_W'(HALF);
    else if (slot_q < SLOT_W'(RUNIN_SLOTS + START_SLOTS))
      bit_o = slot_q == SLOT_W'(RUNIN_SLOTS + START_SLOTS - 1);
    else
      bit_o = data_q[didx];
  end

  assign busy_o = busy_q;

  // R3
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && slot_q == SLOT_W'(RUNIN_SLOTS)) |-> !bit_o);
  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(data_q));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_q);
  // R2
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> slot_q < SLOT_W'(TOTAL_SLOTS));
endmodule

// File: rtl/cc_inserter.sv
`timescale 1ns/1ps
module cc_inserter
  import cc_pkg::*;
#(
  parameter int unsigned BIT_CLKS = 32,
  parameter int unsigned LINE_W   = 10,
  parameter int unsigned H_W      = 11,
  parameter int unsigned START_H  = 140,
  parameter int unsigned LVL_W    = 8,
  parameter int unsigned LVL_HI   = 200,
  parameter int unsigned LVL_LO   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              field_i,
  input  logic [H_W-1:0]    hpos_i,
  output logic              cc_active_o,
  output logic [LVL_W-1:0]  cc_luma_o,
  output logic [1:0]        cc_flags_o,
  output logic              irq_o
);
  localparam int unsigned LINE_A = 21;
  localparam int unsigned LINE_B = 284;

  logic [1:0]  rst_pipe;
  logic        rst_s_n;
  logic [1:0]  en, hit, latch, done_line;
  logic [15:0] pair_a, pair_b;
  logic        busy, ser_bit, ser_done, start;
  logic        cur_q, cur_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  assign hit[0] = line_i == LINE_W'(LINE_A) && !field_i && hpos_i == H_W'(START_H);
  assign hit[1] = line_i == LINE_W'(LINE_B) &&  field_i && hpos_i == H_W'(START_H);
  assign latch  = busy ? 2'b00 : (hit & en);
  assign start  = |latch;

  assign cur_d = start ? latch[1] : cur_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) cur_q <= 1'b0;
    else          cur_q <= cur_d;
  end

  assign done_line = {ser_done && cur_q, ser_done && !cur_q};

  cc_regs u_regs (
    .clk(clk), .rst_n(rst_s_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .latch_i(latch), .done_i(done_line),
    .en_o(en), .pair_a_o(pair_a), .pair_b_o(pair_b),
    .flags_o(cc_flags_o), .irq_o(irq_o)
  );

  cc_serializer #(.BIT_CLKS(BIT_CLKS)) u_ser (
    .clk(clk), .rst_n(rst_s_n),
    .start_i(start), .data_i(latch[1] ? pair_b : pair_a),
    .busy_o(busy), .bit_o(ser_bit), .done_o(ser_done)
  );

  assign cc_active_o = busy;
  assign cc_luma_o   = !busy ? '0 : (ser_bit ? LVL_W'(LVL_HI) : LVL_W'(LVL_LO));

  // R1
  line_gate_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(busy) |-> $past((line_i == LINE_W'(LINE_A) && !field_i) ||
                          (line_i == LINE_W'(LINE_B) &&  field_i)));
  // R10
  idle_luma_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cc_active_o |-> cc_luma_o == '0);
endmodule

// File: tb/cc_inserter_tb.sv
`timescale 1ns/1ps
module cc_inserter_tb;
  localparam int BC = 4;
  localparam int SH = 10;
  localparam int LC = 150;
  localparam int NS = 26;
  localparam int HI = 200;
  localparam int LO = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [9:0] line;
  logic       field;
  logic [10:0] hpos;
  logic       act;
  logic [7:0] luma;
  logic [1:0] flags;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  logic [1:0] expf = 2'b00;
  logic [1:0] mask = 2'b00;

  always #5 clk = ~clk;

  cc_inserter #(.BIT_CLKS(BC), .START_H(SH), .LVL_HI(HI), .LVL_LO(LO)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .line_i(line), .field_i(field), .hpos_i(hpos),
    .cc_active_o(act), .cc_luma_o(luma), .cc_flags_o(flags), .irq_o(irq)
  );

  function automatic logic [7:0] par(input logic [7:0] x);
    return {~(^x[6:0]), x[6:0]};
  endfunction

  function automatic logic exp_bit(input int k, input logic [15:0] d);
    int s = k / BC;
    int t = k % BC;
    if (s < 7) return t < BC/2;
    if (s < 10) return s == 9;
    return d[s-10];
  endfunction

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic check_status(input string req);
    @(negedge clk);
    chk(flags == expf, req, flags, expf);
    chk(irq == |(expf & mask), req, irq, |(expf & mask));
  endtask

  // One scan line; exp_on says a waveform is due with characters c1, c2.
  task automatic run_line(input int ln, input bit fld, input bit exp_on, input int sl,
                          input logic [7:0] c1, input logic [7:0] c2,
                          input bit do_wr, input logic [2:0] wa, input logic [7:0] wd);
    logic [15:0] d = {c2, c1};
    int bad = 0;
    line = 10'(ln); field = fld;
    for (int h = 0; h < LC; h++) begin
      @(posedge clk); #1;
      hpos = 11'(h);
      wr_en = 1'b0;
      if (do_wr && h == SH + 30) begin wr_en = 1'b1; wr_addr = wa; wr_data = wd; end
      @(negedge clk);
      begin
        int k = h - 1 - SH;
        bit ea = exp_on && k >= 0 && k < NS*BC;
        int el = !ea ? 0 : (exp_bit(k, d) ? HI : LO);
        string rq = !ea ? "R1" : (k < 7*BC ? "R2" : (k < 10*BC ? "R3" : (do_wr ? "R6" : "R4")));
        if (act !== ea && bad < 4) begin chk(1'b0, rq, act, ea); bad++; end
        else if (luma !== 8'(el) && bad < 4) begin chk(1'b0, {rq, "/R10"}, luma, el); bad++; end
        else checks++;
        if (exp_on && k == NS*BC) chk(flags[sl] == 1'b1, "R7", flags[sl], 1);
      end
    end
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (exp_on) expf[sl] = 1'b1;
    check_status("R7");
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    line = '0; field = 1'b0; hpos = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(act == 1'b0, "R9", act, 0);
    chk(luma == 8'd0, "R9", luma, 0);
    chk(flags == 2'b00, "R9", flags, 0);
    chk(irq == 1'b0, "R9", irq, 0);

    // R1: enables are 0 after reset
    run_line(21, 1'b0, 1'b0, 0, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00);

    wr(3'd0, 8'h03);
    wr(3'd4, 8'h41);
    wr(3'd5, 8'h87);              // R4: host bit 7 ignored
    run_line(21, 1'b0, 1'b1, 0, par(8'h41), par(8'h07), 1'b0, 3'd0, 8'h00);
    // R1: wrong field / wrong line
    run_line(21, 1'b1, 1'b0, 0, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00);
    run_line(284, 1'b0, 1'b0, 1, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00);
    run_line(22, 1'b0, 1'b0, 0, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00);
    // R5: nothing new written
    run_line(21, 1'b0, 1'b1, 0, 8'h80, 8'h80, 1'b0, 3'd0, 8'h00);

    // R6: write during line 284 transmission
    wr(3'd6, 8'h55);
    wr(3'd7, 8'h2A);
    run_line(284, 1'b1, 1'b1, 1, par(8'h55), par(8'h2A), 1'b1, 3'd6, 8'h11);
    run_line(284, 1'b1, 1'b1, 1, par(8'h11), par(8'h2A), 1'b0, 3'd0, 8'h00);

    // R8 mask and clear
    check_status("R8");
    wr(3'd1, 8'h01); mask = 2'b01; check_status("R8");
    wr(3'd2, 8'h01); expf[0] = 1'b0; check_status("R8");
    wr(3'd1, 8'h02); mask = 2'b10; check_status("R8");
    wr(3'd2, 8'h02); expf[1] = 1'b0; check_status("R8");

    // R1: line 284 disabled
    wr(3'd0, 8'h01);
    run_line(284, 1'b1, 1'b0, 1, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00);

    // R4 sweep over all 7-bit character values
    for (int v = 0; v < 128; v++) begin
      wr(3'd4, 8'(v));
      wr(3'd5, 8'(127 - v) | 8'h80);
      run_line(21, 1'b0, 1'b1, 0, par(8'(v)), par(8'(127 - v)), 1'b0, 3'd0, 8'h00);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule